// File: doc/BRIEF.md
# Coset-Constrained PAM Candidate Enumerator

This block feeds candidate symbols to a tree-search lattice decoder whose search space is one coset of a sublattice. The sublattice is built from the (8,4,4) extended Hamming code. The integer point is valid when the vector of its eight symbol parities, taken modulo two, lies in a chosen coset of that code. The search walks the eight tree levels from level 7 down to level 0. Levels 7..4 carry the code's information bits, so any constellation point is allowed there. At levels 3..0 the parity of the symbol is forced. The forced value depends on the selected coset and on the parities already chosen at levels 7..4.

For each level the caller pulses `start` and supplies:
- the level index,
- a 4-bit coset selector and the 4-bit output of the outer convolutional encoder,
- the parities of the symbols already chosen at levels 7..4,
- the nearest unconstrained PAM point and the sign of the residual around it.

The block then emits, one per `advance` pulse, every admissible PAM point of that level in order of increasing distance from the received value. It raises `exhausted` when none is left. Sixteen copies, one per coset, can run side by side.

Top module: `coset_pam_enum`

## Requirements
- R1: While and directly after reset, `cand_valid` and `exhausted` are 0.
- R2: The effective syndrome is `coset_sel XOR enc_bits`; syndrome bit j governs level j (j = 0..3).
- R3: At levels 7..4 all M = 2^PAM_LOG2 odd points from -(M-1) to M-1 are emitted, each exactly once.
- R4: The symbol bit of a point x is the LSB of (x+M-1)/2. For 4-PAM, -3 and 1 map to 0, while -1 and 3 map to 1. At level j in 0..3 the required bit is syndrome[j] XOR the parity of `upper_par` with bit j cleared. Only the M/2 points carrying that bit are emitted.
- R5: At level j in 0..3, `upper_par[j]` (the parity of level 4+j) has no effect, and at levels 7..4 `upper_par` has no effect at all.
- R6: One cycle after `start`, `cand_valid` is 1 and `cand` holds the nearest admissible point. Each later `advance` presents the next point one cycle later. Points are ordered by distance from center+0.5 when `resid_pos` is 1, and from center-0.5 when it is 0.
- R7: An `advance` with no admissible point left gives `cand_valid`=0 and `exhausted`=1 one cycle later. Both stay so until the next `start`; the two flags are never high together.
- R8: `start` takes priority over a coincident `advance`. An `advance` while `cand_valid` is 0 changes nothing.
- R9: `fixed_par` is 1 for levels 0..3 and 0 for levels 4..7. It and `par_bit`, the required bit of R4, are captured at `start`.
- R10: Every valid `cand` is odd and lies within [-(M-1), M-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new level and emit its first candidate |
| advance | input | 1 | Request the next candidate |
| level | input | 3 | Tree level being expanded (7 = first searched) |
| coset_sel | input | 4 | Coset selector of this decoder copy |
| enc_bits | input | 4 | Outer encoder output bits |
| upper_par | input | 4 | Symbol bits already chosen at levels 4..7 (bit i = level 4+i) |
| center | input | PAM_LOG2+1 | Nearest unconstrained PAM point, signed |
| resid_pos | input | 1 | 1 when the received value lies above `center` |
| cand_valid | output | 1 | `cand` holds an admissible point |
| cand | output | PAM_LOG2+1 | Current candidate, signed |
| exhausted | output | 1 | No admissible point remains at this level |
| fixed_par | output | 1 | This level's symbol bit is forced |
| par_bit | output | 1 | Forced symbol bit when `fixed_par` is 1 |

## Verification
A `start` for a new level and an `advance` for the old one can arrive in the same cycle. The bench raises both at one clock edge. It then requires the nearest point of the new level, not a step along the old walk. Running out of candidates and reloading can also meet. The bench drains a level into `exhausted` and issues further `advance` pulses, which must leave the flags and `cand` alone. The next `start` must clear `exhausted` in the same cycle that a fresh candidate appears. Expected sequences come from a sort by distance in the bench.

// File: rtl/coset_pam_pkg.sv
package coset_pam_pkg;
   // depth of the search tree: one level per dimension of the lattice
   localparam int unsigned TREE_LEVELS = 8;
   localparam int unsigned LVL_W       = $clog2(TREE_LEVELS);
   // levels at or above this index carry information bits of the code
   localparam int unsigned FREE_BASE   = TREE_LEVELS / 2;
   localparam int unsigned CHK_W       = TREE_LEVELS - FREE_BASE;

   // information bits that enter the parity check of constrained level j
   function automatic logic [CHK_W-1:0] check_mask(input int unsigned j);
      return {CHK_W{1'b1}} & ~(CHK_W'(1) << j);
   endfunction
endpackage

// File: rtl/coset_parity_rule.sv
module coset_parity_rule
   import coset_pam_pkg::*;
(
   input  logic [LVL_W-1:0] level,
   input  logic [CHK_W-1:0] syndrome,
   input  logic [CHK_W-1:0] upper_par,
   output logic             fixed,
   output logic             req_bit
);
   logic [CHK_W-1:0] check_bit;

   for (genvar j = 0; j < CHK_W; j++) begin : g_check
      assign check_bit[j] = syndrome[j] ^ (^(upper_par & check_mask(j)));
   end

   assign fixed   = (level < LVL_W'(FREE_BASE));
   assign req_bit = check_bit[level[$clog2(CHK_W)-1:0]];
endmodule

// File: rtl/coset_anchor_pick.sv
module coset_anchor_pick #(
   parameter int unsigned PAM_LOG2 = 2
) (
   input  logic signed [PAM_LOG2:0]   center,
   input  logic                       resid_pos,
   input  logic                       fixed,
   input  logic                       req_bit,
   output logic signed [PAM_LOG2+2:0] anchor,
   output logic signed [PAM_LOG2+2:0] stride,
   output logic                       first_up
);
   localparam int unsigned SYM_W = PAM_LOG2 + 1;
   localparam int unsigned PW    = PAM_LOG2 + 3;
   localparam logic signed [PW-1:0] VMAX = PW'((1 << PAM_LOG2) - 1);
   localparam logic signed [PW-1:0] VMIN = -VMAX;
   localparam logic PAR_FLIP = (PAM_LOG2 == 1);

   logic signed [PW-1:0] c_ext, c_hi, c_lo;
   logic                 c_bit;

   always_comb begin
      c_ext = {{(PW-SYM_W){center[SYM_W-1]}}, center};
      c_hi  = c_ext + PW'(2);
      c_lo  = c_ext - PW'(2);
      c_bit = center[1] ^ PAR_FLIP;
      stride = fixed ? PW'(4) : PW'(2);
      if (!fixed || (c_bit == req_bit)) begin
         anchor   = c_ext;
         first_up = resid_pos;
      end else if ((resid_pos && (c_hi <= VMAX)) || (!resid_pos && (c_lo < VMIN))) begin
         anchor   = c_hi;
         first_up = 1'b0;
      end else begin
         anchor   = c_lo;
         first_up = 1'b1;
      end
   end
endmodule

// File: rtl/coset_zigzag_walk.sv
module coset_zigzag_walk #(
   parameter int unsigned PAM_LOG2 = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic                       advance,
   input  logic signed [PAM_LOG2+2:0] anchor,
   input  logic signed [PAM_LOG2+2:0] stride,
   input  logic                       first_up,
   output logic signed [PAM_LOG2:0]   cur,
   output logic                       valid,
   output logic                       exhausted
);
   localparam int unsigned SYM_W = PAM_LOG2 + 1;
   localparam int unsigned PW    = PAM_LOG2 + 3;
   localparam logic signed [PW-1:0] VMAX = PW'((1 << PAM_LOG2) - 1);
   localparam logic signed [PW-1:0] VMIN = -VMAX;

   logic signed [PW-1:0] up_ptr, dn_ptr, step_r;
   logic                 pref_up;
   logic                 up_ok, dn_ok, take_up, take_dn;

   always_comb begin
      up_ok   = (up_ptr <= VMAX);
      dn_ok   = (dn_ptr >= VMIN);
      take_up = up_ok && (pref_up || !dn_ok);
      take_dn = dn_ok && !take_up;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur       <= '0;
         valid     <= 1'b0;
         exhausted <= 1'b0;
         up_ptr    <= '0;
         dn_ptr    <= '0;
         step_r    <= '0;
         pref_up   <= 1'b0;
      end else if (load) begin
         cur       <= anchor[SYM_W-1:0];
         valid     <= 1'b1;
         exhausted <= 1'b0;
         up_ptr    <= anchor + stride;
         dn_ptr    <= anchor - stride;
         step_r    <= stride;
         pref_up   <= first_up;
      end else if (advance && valid) begin
         if (take_up) begin
            cur     <= up_ptr[SYM_W-1:0];
            up_ptr  <= up_ptr + step_r;
            pref_up <= 1'b0;
         end else if (take_dn) begin
            cur     <= dn_ptr[SYM_W-1:0];
            dn_ptr  <= dn_ptr - step_r;
            pref_up <= 1'b1;
         end else begin
            valid     <= 1'b0;
            exhausted <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/coset_pam_enum.sv
module coset_pam_enum
   import coset_pam_pkg::*;
#(
   parameter int unsigned PAM_LOG2 = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     advance,
   input  logic [2:0]               level,
   input  logic [3:0]               coset_sel,
   input  logic [3:0]               enc_bits,
   input  logic [3:0]               upper_par,
   input  logic signed [PAM_LOG2:0] center,
   input  logic                     resid_pos,
   output logic                     cand_valid,
   output logic signed [PAM_LOG2:0] cand,
   output logic                     exhausted,
   output logic                     fixed_par,
   output logic                     par_bit
);
   localparam int unsigned PW = PAM_LOG2 + 3;

   if (PAM_LOG2 < 1 || PAM_LOG2 > 6) begin : g_bad_pam
      $error("coset_pam_enum: PAM_LOG2 must lie in 1..6");
   end
   if (LVL_W != 3 || CHK_W != 4) begin : g_bad_tree
      $error("coset_pam_enum: tree shape does not match port widths");
   end

   logic [3:0]           syndrome;
   logic                 lvl_fixed, lvl_bit, first_up;
   logic signed [PW-1:0] anchor, stride;

   assign syndrome = coset_sel ^ enc_bits;

   coset_parity_rule u_rule (
      .level     (level),
      .syndrome  (syndrome),
      .upper_par (upper_par),
      .fixed     (lvl_fixed),
      .req_bit   (lvl_bit)
   );

   coset_anchor_pick #(.PAM_LOG2(PAM_LOG2)) u_pick (
      .center    (center),
      .resid_pos (resid_pos),
      .fixed     (lvl_fixed),
      .req_bit   (lvl_bit),
      .anchor    (anchor),
      .stride    (stride),
      .first_up  (first_up)
   );

   coset_zigzag_walk #(.PAM_LOG2(PAM_LOG2)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start),
      .advance   (advance),
      .anchor    (anchor),
      .stride    (stride),
      .first_up  (first_up),
      .cur       (cand),
      .valid     (cand_valid),
      .exhausted (exhausted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fixed_par <= 1'b0;
         par_bit   <= 1'b0;
      end else if (start) begin
         fixed_par <= lvl_fixed;
         par_bit   <= lvl_fixed & lvl_bit;
      end
   end
endmodule

// File: rtl/coset_pam_enum_chk.sv
module coset_pam_enum_chk #(
   parameter int unsigned PAM_LOG2 = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     start,
   input logic                     advance,
   input logic [2:0]               level,
   input logic                     cand_valid,
   input logic signed [PAM_LOG2:0] cand,
   input logic                     exhausted,
   input logic                     fixed_par,
   input logic                     par_bit
);
   localparam int VMAXI = (1 << PAM_LOG2) - 1;
   localparam logic PAR_FLIP = (PAM_LOG2 == 1);

   assert_start_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cand_valid && !exhausted));

   assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cand_valid |-> (cand[0] && (int'(cand) <= VMAXI) && (int'(cand) >= -VMAXI)));

   assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(cand_valid && exhausted));

   assert_forced_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_valid && fixed_par) |-> ((cand[1] ^ PAR_FLIP) == par_bit));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !(advance && cand_valid)) |=>
         ($stable(cand) && $stable(cand_valid) && $stable(exhausted)));

   assert_free_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && level[2]) |=> !fixed_par);
endmodule

bind coset_pam_enum coset_pam_enum_chk #(.PAM_LOG2(PAM_LOG2)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .advance    (advance),
   .level      (level),
   .cand_valid (cand_valid),
   .cand       (cand),
   .exhausted  (exhausted),
   .fixed_par  (fixed_par),
   .par_bit    (par_bit)
);

// File: tb/coset_pam_enum_bench.sv
module coset_pam_enum_bench;
   localparam int PL = 2;
   localparam int M  = 1 << PL;
   localparam int SW = PL + 1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic                 rst_n, start, advance, resid_pos;
   logic [2:0]           level;
   logic [3:0]           coset_sel, enc_bits, upper_par;
   logic signed [SW-1:0] center, cand;
   logic                 cand_valid, exhausted, fixed_par, par_bit;

   int checks = 0;
   int fails  = 0;

   coset_pam_enum #(.PAM_LOG2(PL)) u_coset_pam_enum (
      .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
      .level(level), .coset_sel(coset_sel), .enc_bits(enc_bits),
      .upper_par(upper_par), .center(center), .resid_pos(resid_pos),
      .cand_valid(cand_valid), .cand(cand), .exhausted(exhausted),
      .fixed_par(fixed_par), .par_bit(par_bit)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int par4(input int v);
      return (v & 1) ^ ((v >> 1) & 1) ^ ((v >> 2) & 1) ^ ((v >> 3) & 1);
   endfunction

   function automatic int sym_bit(input int x);
      return ((x + M - 1) / 2) & 1;
   endfunction

   // one full level: load, walk every candidate, then one extra advance
   task automatic run_case(input int lv, input int sel, input int enc, input int up,
                           input int c, input int rp, input logic with_adv,
                           output int seen_bit);
      int lst[64];
      int n, t2, rq, fx, tmp;
      n  = 0;
      fx = (lv < 4) ? 1 : 0;
      rq = 0;
      if (fx == 1) rq = (((sel ^ enc) >> lv) & 1) ^ par4(up & ~(1 << lv) & 15);
      for (int x = -(M - 1); x <= M - 1; x += 2) begin
         if (fx == 0 || sym_bit(x) == rq) begin
            lst[n] = x;
            n++;
         end
      end
      t2 = 2 * c + ((rp != 0) ? 1 : -1);
      for (int i = 0; i < n; i++) begin
         for (int k = i + 1; k < n; k++) begin
            if ((2 * lst[k] - t2) * (2 * lst[k] - t2) < (2 * lst[i] - t2) * (2 * lst[i] - t2)) begin
               tmp = lst[i]; lst[i] = lst[k]; lst[k] = tmp;
            end
         end
      end
      @(negedge clk);
      level = 3'(lv); coset_sel = 4'(sel); enc_bits = 4'(enc);
      upper_par = 4'(up); center = SW'(c); resid_pos = (rp != 0);
      start = 1'b1; advance = with_adv;
      @(negedge clk);
      start = 1'b0; advance = 1'b0;
      seen_bit = int'(par_bit);
      chk(fixed_par == fx[0], "R9", int'(fixed_par), fx);
      if (fx == 1) chk(par_bit == rq[0], "R2", int'(par_bit), rq);
      chk(cand_valid && !exhausted && (int'(cand) == lst[0]), "R6", int'(cand), lst[0]);
      for (int k = 1; k < n; k++) begin
         advance = 1'b1;
         @(negedge clk);
         chk(cand_valid && (int'(cand) == lst[k]), (fx == 1) ? "R4" : "R3", int'(cand), lst[k]);
         chk(cand[0] && int'(cand) <= M - 1 && int'(cand) >= -(M - 1), "R10", int'(cand), lst[k]);
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      chk(!cand_valid && exhausted, "R7", int'(exhausted), 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int b0, b1, hold_c;
      rst_n = 1'b0; start = 1'b0; advance = 1'b0; level = '0; coset_sel = '0;
      enc_bits = '0; upper_par = '0; center = '0; resid_pos = 1'b0;
      repeat (3) @(negedge clk);
      chk(!cand_valid && !exhausted, "R1", int'(cand_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cand_valid && !exhausted, "R1", int'(exhausted), 0);

      // advance before any level is loaded changes nothing
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      chk(!cand_valid && !exhausted, "R8", int'(cand_valid), 0);

      // start and advance together: the new level's nearest point wins
      run_case(2, 6, 3, 9, -1, 1, 1'b1, b0);
      run_case(6, 0, 0, 0, 3, 0, 1'b1, b0);

      // after exhaustion, extra advances hold every output
      hold_c = int'(cand);
      for (int k = 0; k < 3; k++) begin
         advance = 1'b1;
         @(negedge clk);
         chk(!cand_valid && exhausted && int'(cand) == hold_c, "R8", int'(cand), hold_c);
      end
      advance = 1'b0;

      // own parity bit of the governed level never matters
      for (int j = 0; j < 4; j++) begin
         for (int up = 0; up < 16; up++) begin
            run_case(j, 5, 12, up, 1, 1, 1'b0, b0);
            run_case(j, 5, 12, up ^ (1 << j), 1, 1, 1'b0, b1);
            chk(b0 == b1, "R5", b1, b0);
         end
      end
      for (int up = 0; up < 16; up++) begin
         run_case(5, 9, 2, up, -3, 0, 1'b0, b0);
         chk(b0 == 0, "R5", b0, 0);
      end

      // full sweep of level, coset, encoder bits, upper parities, center, residual
      for (int lv = 0; lv < 8; lv++) begin
         for (int sel = 0; sel < 16; sel++) begin
            for (int hi = 0; hi < ((lv < 4) ? 16 : 2); hi++) begin
               for (int ci = 0; ci < M; ci++) begin
                  for (int rp = 0; rp < 2; rp++) begin
                     run_case(lv, sel, (sel * 7 + hi * 3) & 15,
                              (lv < 4) ? hi : hi * 10, 2 * ci - (M - 1), rp, 1'b0, b0);
                  end
               end
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule